// File: doc/BRIEF.md
# Dual Inset Window Compositor

This block decides, for every display pixel, which picture source the output mixer should show. It is driven by the display-side horizontal pixel counter and line counter, and by a static set of layout settings. There are two inset windows (a main inset and a sub inset), each with an optional frame around it, a fixed-size background plane, and the live main video underneath everything. For the pixel under the counters it returns a 3-bit select code, together with a fast-blanking strobe that tells a downstream keyer when inserted content is on screen.

Each inset's size comes from its reduction factors, scaled against a full line of 1408 samples and against a field height that depends on the line standard. Its position is given in coarse steps. When the two insets overlap, a priority bit decides which one is drawn on top. The fast-blanking strobe is given as two half-pixel phases. This lets the keying edge be moved by half a pixel or a whole pixel, either way, relative to the select code, so that it can be matched to delays further down the video path.

Top module: `pip_compositor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pix_sel` is 0 (main video) and `fb_half` is 00.
- R2: The select code for the counter values sampled at clock edge k is on `pix_sel` after edge k+1, which is a latency of two registers. The counters need not be contiguous.
- R3: An inset covers pixels `hpos*8 <= h < hpos*8 + floor(hred*1408/96)` and lines `vpos <= v < vpos + floor(vred*L/96)`. L is 228 when `pal_mode`=0 and 276 when `pal_mode`=1.
- R4: An inset whose horizontal or vertical reduction value is 0 is off. Neither its picture nor its frame is selected.
- R5: Where both insets (with their frames) cover a pixel, the main inset wins when `sub_on_top`=0 and the sub inset wins when `sub_on_top`=1.
- R6: When `border_en`=1, each active inset has a frame of `2*border_width` pixels on its left and right and `border_width` lines above and below, drawn with code 3. When `border_en`=0, no frame is drawn.
- R7: When `bg_en`=1, the background covers pixels `bg_hpos*4 <= h < bg_hpos*4+720` and lines `bg_vpos <= v < bg_vpos+H`, where H is 240 (`pal_mode`=0) or 288 (`pal_mode`=1). It lies beneath both insets and their frames and is never shown when `bg_en`=0.
- R8: Select codes are: 0 main video, 1 main inset, 2 sub inset, 3 frame colour, 4 background colour. No other value appears.
- R9: Let c be the inserted flag (`pix_sel`≠0) of the current pixel, p that of the previous pixel and n that of the next one. `fb_half[0]` is the first half-pixel and `fb_half[1]` is the second. The shift code gives: 00 → {c,c}; 01 (+0.5) → first p, second c; 10 (−0.5) → first c, second n; 11 (−1) → {n,n}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous active-high reset |
| h_count | input | HCW (11) | display pixel counter |
| v_count | input | VCW (9) | display line counter within the field |
| main_hpos | input | POSW (8) | main inset horizontal start, units of 8 pixels |
| main_vpos | input | POSW (8) | main inset first line |
| main_hred | input | HREDW (6) | main inset horizontal reduction, 0..48 |
| main_vred | input | VREDW (7) | main inset vertical reduction, 0..96 |
| sub_hpos | input | POSW (8) | sub inset horizontal start, units of 8 pixels |
| sub_vpos | input | POSW (8) | sub inset first line |
| sub_hred | input | HREDW (6) | sub inset horizontal reduction |
| sub_vred | input | VREDW (7) | sub inset vertical reduction |
| pal_mode | input | 1 | 1 selects 625-line field heights |
| border_en | input | 1 | enables inset frames |
| border_width | input | BWW (3) | frame thickness step |
| bg_en | input | 1 | enables background plane |
| bg_hpos | input | BGPW (4) | background horizontal start, units of 4 pixels |
| bg_vpos | input | BGPW (4) | background first line |
| sub_on_top | input | 1 | overlap priority |
| blank_shift | input | 2 | fast-blank shift code |
| pix_sel | output | 3 | per-pixel source select |
| fb_half | output | 2 | fast-blank strobe, two half-pixel phases |

## Verification
Raster patches are scanned across every window edge, with a single inset, two overlapping insets under both priorities, framed and unframed insets, and the background alone and under an inset. This separates off-by-one errors at start and end edges, a swapped priority, frame thickness errors, and layering order. Each geometry is run in both line standards, and with zero reduction on either axis, so that field-height selection is checked and so is the gating of a disabled inset. The same inset edges are scanned under all four blanking shift codes. Neighbouring expected pixels from the stream give the half-pixel phases, which exposes a shift in the wrong direction.

// File: rtl/pip_comp_pkg.sv
package pip_comp_pkg;

    typedef enum logic [2:0] {
        SEL_MAIN   = 3'd0,
        SEL_MINSET = 3'd1,
        SEL_SINSET = 3'd2,
        SEL_BORDER = 3'd3,
        SEL_BACK   = 3'd4
    } pix_sel_e;

    typedef struct packed {
        logic inner;
        logic outer;
    } win_hit_t;

    localparam int LINE_SAMPLES   = 1408;
    localparam int RED_DENOM      = 96;
    localparam int LINES_NTSC     = 228;
    localparam int LINES_PAL      = 276;
    localparam int BG_WIDTH       = 720;
    localparam int BG_LINES_NTSC  = 240;
    localparam int BG_LINES_PAL   = 288;
    localparam int INSET_H_SHIFT  = 3;
    localparam int BG_H_SHIFT     = 2;

    function automatic int inset_width(input int red);
        return (red * LINE_SAMPLES) / RED_DENOM;
    endfunction

    function automatic int inset_height(input int red, input logic pal);
        return (red * (pal ? LINES_PAL : LINES_NTSC)) / RED_DENOM;
    endfunction

    function automatic pix_sel_e inset_code(input logic idx);
        return idx ? SEL_SINSET : SEL_MINSET;
    endfunction

endpackage

// File: rtl/pip_window.sv
module pip_window
    import pip_comp_pkg::*;
#(
    parameter int HCW   = 11,
    parameter int VCW   = 9,
    parameter int POSW  = 8,
    parameter int HREDW = 6,
    parameter int VREDW = 7,
    parameter int BWW   = 3
) (
    input  logic [HCW-1:0]   h_count,
    input  logic [VCW-1:0]   v_count,
    input  logic [POSW-1:0]  hpos,
    input  logic [POSW-1:0]  vpos,
    input  logic [HREDW-1:0] hred,
    input  logic [VREDW-1:0] vred,
    input  logic             pal_mode,
    input  logic             border_en,
    input  logic [BWW-1:0]   border_width,
    output win_hit_t         hit
);
    localparam int HX = HCW + 3;
    localparam int VX = VCW + 2;

    logic [HX-1:0] hx, h_lo, h_hi, h_pad;
    logic [VX-1:0] vx, v_lo, v_hi, v_pad;
    logic          active;

    always_comb begin
        hx     = HX'(h_count);
        vx     = VX'(v_count);
        h_lo   = HX'(hpos) << INSET_H_SHIFT;
        h_hi   = h_lo + HX'(inset_width(int'(hred)));
        v_lo   = VX'(vpos);
        v_hi   = v_lo + VX'(inset_height(int'(vred), pal_mode));
        h_pad  = border_en ? (HX'(border_width) << 1) : '0;
        v_pad  = border_en ? VX'(border_width) : '0;
        active = (hred != '0) && (vred != '0);
        hit.inner = active && (hx >= h_lo) && (hx < h_hi)
                           && (vx >= v_lo) && (vx < v_hi);
        hit.outer = active && ((hx + h_pad) >= h_lo) && (hx < (h_hi + h_pad))
                           && ((vx + v_pad) >= v_lo) && (vx < (v_hi + v_pad));
    end

endmodule

// File: rtl/pip_bg_window.sv
module pip_bg_window
    import pip_comp_pkg::*;
#(
    parameter int HCW  = 11,
    parameter int VCW  = 9,
    parameter int BGPW = 4
) (
    input  logic [HCW-1:0]  h_count,
    input  logic [VCW-1:0]  v_count,
    input  logic [BGPW-1:0] bg_hpos,
    input  logic [BGPW-1:0] bg_vpos,
    input  logic            bg_en,
    input  logic            pal_mode,
    output logic            hit
);
    localparam int HX = HCW + 3;
    localparam int VX = VCW + 2;

    logic [HX-1:0] hx, h_lo, h_hi;
    logic [VX-1:0] vx, v_lo, v_hi;

    always_comb begin
        hx   = HX'(h_count);
        vx   = VX'(v_count);
        h_lo = HX'(bg_hpos) << BG_H_SHIFT;
        h_hi = h_lo + HX'(BG_WIDTH);
        v_lo = VX'(bg_vpos);
        v_hi = v_lo + VX'(pal_mode ? BG_LINES_PAL : BG_LINES_NTSC);
        hit  = bg_en && (hx >= h_lo) && (hx < h_hi) && (vx >= v_lo) && (vx < v_hi);
    end

endmodule

// File: rtl/pip_blank_shift.sv
module pip_blank_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] shift_code,
    input  logic       flag_next,
    input  logic       flag_cur,
    output logic [1:0] fb_half
);
    logic flag_prev;

    always_ff @(posedge clk) begin
        if (rst) flag_prev <= 1'b0;
        else     flag_prev <= flag_cur;
    end

    // bit 0 = first half-pixel, bit 1 = second half-pixel
    always_comb begin
        unique case (shift_code)
            2'b00:   fb_half = {flag_cur,  flag_cur};
            2'b01:   fb_half = {flag_cur,  flag_prev};
            2'b10:   fb_half = {flag_next, flag_cur};
            default: fb_half = {flag_next, flag_next};
        endcase
    end

endmodule

// File: rtl/pip_compositor.sv
module pip_compositor
    import pip_comp_pkg::*;
#(
    parameter int HCW   = 11,
    parameter int VCW   = 9,
    parameter int POSW  = 8,
    parameter int HREDW = 6,
    parameter int VREDW = 7,
    parameter int BWW   = 3,
    parameter int BGPW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HCW-1:0]   h_count,
    input  logic [VCW-1:0]   v_count,
    input  logic [POSW-1:0]  main_hpos,
    input  logic [POSW-1:0]  main_vpos,
    input  logic [HREDW-1:0] main_hred,
    input  logic [VREDW-1:0] main_vred,
    input  logic [POSW-1:0]  sub_hpos,
    input  logic [POSW-1:0]  sub_vpos,
    input  logic [HREDW-1:0] sub_hred,
    input  logic [VREDW-1:0] sub_vred,
    input  logic             pal_mode,
    input  logic             border_en,
    input  logic [BWW-1:0]   border_width,
    input  logic             bg_en,
    input  logic [BGPW-1:0]  bg_hpos,
    input  logic [BGPW-1:0]  bg_vpos,
    input  logic             sub_on_top,
    input  logic [1:0]       blank_shift,
    output logic [2:0]       pix_sel,
    output logic [1:0]       fb_half
);
    localparam int NWIN = 2;

    logic [POSW-1:0]  w_hpos [NWIN];
    logic [POSW-1:0]  w_vpos [NWIN];
    logic [HREDW-1:0] w_hred [NWIN];
    logic [VREDW-1:0] w_vred [NWIN];

    assign w_hpos[0] = main_hpos;  assign w_hpos[1] = sub_hpos;
    assign w_vpos[0] = main_vpos;  assign w_vpos[1] = sub_vpos;
    assign w_hred[0] = main_hred;  assign w_hred[1] = sub_hred;
    assign w_vred[0] = main_vred;  assign w_vred[1] = sub_vred;

    win_hit_t hit_c [NWIN];
    win_hit_t hit_q [NWIN];
    logic     bg_c, bg_q;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        pip_window #(
            .HCW(HCW), .VCW(VCW), .POSW(POSW),
            .HREDW(HREDW), .VREDW(VREDW), .BWW(BWW)
        ) u_win (
            .h_count     (h_count),
            .v_count     (v_count),
            .hpos        (w_hpos[i]),
            .vpos        (w_vpos[i]),
            .hred        (w_hred[i]),
            .vred        (w_vred[i]),
            .pal_mode    (pal_mode),
            .border_en   (border_en),
            .border_width(border_width),
            .hit         (hit_c[i])
        );
    end

    pip_bg_window #(.HCW(HCW), .VCW(VCW), .BGPW(BGPW)) u_bg (
        .h_count (h_count),
        .v_count (v_count),
        .bg_hpos (bg_hpos),
        .bg_vpos (bg_vpos),
        .bg_en   (bg_en),
        .pal_mode(pal_mode),
        .hit     (bg_c)
    );

    // Stage A: registered window compares
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWIN; i++) hit_q[i] <= '0;
            bg_q <= 1'b0;
        end else begin
            for (int i = 0; i < NWIN; i++) hit_q[i] <= hit_c[i];
            bg_q <= bg_c;
        end
    end

    // Layer arbitration on stage A
    logic     top_i, bot_i;
    pix_sel_e arb_sel, sel_q;

    always_comb begin
        top_i   = sub_on_top;
        bot_i   = ~sub_on_top;
        arb_sel = SEL_MAIN;
        if (hit_q[top_i].outer)
            arb_sel = hit_q[top_i].inner ? inset_code(top_i) : SEL_BORDER;
        else if (hit_q[bot_i].outer)
            arb_sel = hit_q[bot_i].inner ? inset_code(bot_i) : SEL_BORDER;
        else if (bg_q)
            arb_sel = SEL_BACK;
    end

    // Stage B: select output
    always_ff @(posedge clk) begin
        if (rst) sel_q <= SEL_MAIN;
        else     sel_q <= arb_sel;
    end

    assign pix_sel = sel_q;

    pip_blank_shift u_fb (
        .clk       (clk),
        .rst       (rst),
        .shift_code(blank_shift),
        .flag_next (arb_sel != SEL_MAIN),
        .flag_cur  (sel_q != SEL_MAIN),
        .fb_half   (fb_half)
    );

    // R8
    sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q <= SEL_BACK);

    // R7
    bg_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bg_en, 2) |-> sel_q != SEL_BACK);

    // R6
    border_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(border_en, 2) |-> sel_q != SEL_BORDER);

    // R4
    main_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(main_hred, 2) == '0) |-> sel_q != SEL_MINSET);

    // R4
    sub_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sub_vred, 2) == '0) |-> sel_q != SEL_SINSET);

    // R9
    fb_noshift_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_shift == 2'b00) |-> fb_half == {2{sel_q != SEL_MAIN}});

    // R9
    fb_late_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_shift == 2'b01 && $past(blank_shift) == 2'b01)
            |-> fb_half[0] == $past(fb_half[1]));

    // R9
    fb_early_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_shift == 2'b11 && $past(blank_shift) == 2'b11)
            |-> $past(fb_half[0]) == (sel_q != SEL_MAIN));

endmodule

// File: tb/pip_compositor_tb_top.sv
module pip_compositor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] hc = '0;
    logic [8:0]  vc = '0;
    logic [7:0]  m_hp = '0, m_vp = '0, s_hp = '0, s_vp = '0;
    logic [5:0]  m_hr = '0, s_hr = '0;
    logic [6:0]  m_vr = '0, s_vr = '0;
    logic        pal = 1'b0, b_en = 1'b0, g_en = 1'b0, prio = 1'b0;
    logic [2:0]  b_w = '0;
    logic [3:0]  g_hp = '0, g_vp = '0;
    logic [1:0]  shf = '0;
    logic [2:0]  pix_sel;
    logic [1:0]  fb_half;

    always #10 clk = ~clk;

    pip_compositor dut_i (
        .clk(clk), .rst(rst), .h_count(hc), .v_count(vc),
        .main_hpos(m_hp), .main_vpos(m_vp), .main_hred(m_hr), .main_vred(m_vr),
        .sub_hpos(s_hp), .sub_vpos(s_vp), .sub_hred(s_hr), .sub_vred(s_vr),
        .pal_mode(pal), .border_en(b_en), .border_width(b_w),
        .bg_en(g_en), .bg_hpos(g_hp), .bg_vpos(g_vp),
        .sub_on_top(prio), .blank_shift(shf),
        .pix_sel(pix_sel), .fb_half(fb_half)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    bit    running = 1'b0;
    bit    have_prev = 1'b0;
    bit    prev_f = 1'b0;
    int    exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 40)
                $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, hc, vc);
        end
    endtask

    function automatic bit in_box(int h, int v, int x0, int y0, int w, int ht);
        return (h >= x0) && (h < x0 + w) && (v >= y0) && (v < y0 + ht);
    endfunction

    // reference model of R3..R8
    function automatic int model_sel(int h, int v);
        int  hp[2], vp[2], hr[2], vr[2];
        bit  inn[2], out[2];
        int  bh, bv, lines, top, bot;
        hp[0] = m_hp; vp[0] = m_vp; hr[0] = m_hr; vr[0] = m_vr;
        hp[1] = s_hp; vp[1] = s_vp; hr[1] = s_hr; vr[1] = s_vr;
        bh    = b_en ? 2 * int'(b_w) : 0;
        bv    = b_en ? int'(b_w) : 0;
        lines = pal ? 276 : 228;
        for (int i = 0; i < 2; i++) begin
            int x0, y0, w, ht;
            bit on;
            on = (hr[i] != 0) && (vr[i] != 0);
            x0 = hp[i] * 8;
            y0 = vp[i];
            w  = (hr[i] * 1408) / 96;
            ht = (vr[i] * lines) / 96;
            inn[i] = on && in_box(h, v, x0, y0, w, ht);
            out[i] = on && in_box(h, v, x0 - bh, y0 - bv, w + 2 * bh, ht + 2 * bv);
        end
        top = prio ? 1 : 0;
        bot = 1 - top;
        if (out[top]) return inn[top] ? top + 1 : 3;
        if (out[bot]) return inn[bot] ? bot + 1 : 3;
        if (g_en && in_box(h, v, g_hp * 4, g_vp, 720, pal ? 288 : 240)) return 4;
        return 0;
    endfunction

    // driver side: expected item per pixel presented at an edge
    always @(posedge clk) begin
        if (running) exp_q.push_back(model_sel(int'(hc), int'(vc)));
    end

    // monitor: compares two edges later (R2)
    always @(posedge clk) begin
        #5;
        if (exp_q.size() >= 2) begin
            int e, nx;
            bit c, n;
            logic [1:0] efb;
            e  = exp_q.pop_front();
            nx = exp_q[0];
            c  = (e != 0);
            n  = (nx != 0);
            chk(int'(pix_sel) == e, cur_tag, int'(pix_sel), e);
            case (shf)
                2'b00:   efb = {c, c};
                2'b01:   efb = {c, prev_f};
                2'b10:   efb = {n, c};
                default: efb = {n, n};
            endcase
            if (!(shf == 2'b01 && !have_prev))
                chk(fb_half == efb, {cur_tag, " R9"}, int'(fb_half), int'(efb));
            prev_f    = c;
            have_prev = 1'b1;
        end
    end

    task automatic flush(input string tag);
        @(negedge clk);
        running = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        have_prev = 1'b0;
        cur_tag   = tag;
    endtask

    task automatic scan(input string tag, input int v0, input int v1, input int h0, input int h1);
        flush(tag);
        for (int v = v0; v <= v1; v++) begin
            for (int h = h0; h <= h1; h++) begin
                if (!(v == v0 && h == h0)) @(negedge clk);
                hc = 11'(h);
                vc = 9'(v);
                running = 1'b1;
            end
        end
        @(negedge clk);
        running = 1'b0;
    endtask

    task automatic clear_cfg();
        m_hp = '0; m_vp = '0; m_hr = '0; m_vr = '0;
        s_hp = '0; s_vp = '0; s_hr = '0; s_vr = '0;
        pal = 0; b_en = 0; b_w = '0; g_en = 0; g_hp = '0; g_vp = '0;
        prio = 0; shf = '0;
    endtask

    task automatic main_std();
        m_hp = 8'd4; m_vp = 8'd10; m_hr = 6'd24; m_vr = 7'd48;
    endtask

    initial begin
        #(64'd20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        main_std();
        hc = 11'd40; vc = 9'd20;
        g_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, even with a covered pixel on the counters
        chk(pix_sel == 3'd0, "R1", int'(pix_sel), 0);
        chk(fb_half == 2'b00, "R1", int'(fb_half), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pix_sel == 3'd0, "R1", int'(pix_sel), 0);
        clear_cfg();

        // R3 R8 R2: main inset edges, NTSC
        main_std();
        scan("R3", 8, 12, 28, 36);
        scan("R3", 121, 125, 378, 388);
        // R3: PAL height and full width
        pal = 1'b1;
        scan("R3", 145, 150, 30, 34);
        m_hr = 6'd48;
        scan("R3", 20, 20, 728, 740);
        pal = 1'b0;

        // R4: zero reduction on either axis
        m_hr = 6'd0; m_vr = 7'd48; b_en = 1'b1; b_w = 3'd2;
        scan("R4", 18, 22, 28, 40);
        m_hr = 6'd24; m_vr = 7'd0;
        s_hp = 8'd4; s_vp = 8'd10; s_hr = 6'd24; s_vr = 7'd0;
        scan("R4", 18, 22, 28, 40);
        clear_cfg();

        // R5: overlap with both priorities
        main_std();
        s_hp = 8'd20; s_vp = 8'd50; s_hr = 6'd24; s_vr = 7'd48;
        prio = 1'b0;
        scan("R5", 49, 51, 156, 164);
        scan("R5", 122, 125, 380, 388);
        prio = 1'b1;
        scan("R5", 49, 51, 156, 164);
        scan("R5", 122, 125, 380, 388);
        b_en = 1'b1; b_w = 3'd2;
        scan("R5", 47, 52, 150, 166);
        clear_cfg();

        // R6: frame on and off
        main_std();
        b_en = 1'b1; b_w = 3'd3;
        scan("R6", 5, 12, 24, 34);
        scan("R6", 122, 128, 380, 392);
        b_w = 3'd7;
        scan("R6", 1, 4, 16, 20);
        b_en = 1'b0; b_w = 3'd3;
        scan("R6", 5, 12, 24, 34);
        clear_cfg();

        // R7: background plane
        g_en = 1'b1; g_hp = 4'd5; g_vp = 4'd3;
        scan("R7", 2, 4, 18, 22);
        scan("R7", 241, 243, 736, 742);
        pal = 1'b1;
        scan("R7", 289, 291, 100, 102);
        pal = 1'b0;
        main_std();
        b_en = 1'b1; b_w = 3'd1;
        scan("R7", 8, 11, 28, 34);
        g_en = 1'b0;
        scan("R7", 2, 4, 18, 22);
        clear_cfg();

        // R9: all blanking shift codes across inset edges
        main_std();
        for (int s = 0; s < 4; s++) begin
            shf = 2'(s);
            scan("R9", 20, 21, 28, 36);
            scan("R9", 20, 20, 380, 388);
        end

        flush("R9");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule